// File: doc/BRIEF.md
# Programmable I/O Chip-Select Decoder

This block produces a set of active-low chip-select strobes for external peripherals. Each select has its own programmable comparator that looks at the low 16 bits of the processor address. Software programs three things for each select: a base address, a size code that sets how many of the upper address bits take part in the compare, and an enable bit. The size code sets a decode window that is a power of two from 8 bytes to 512 bytes. Address bits below the window are ignored, and so are the bits of the base below the window.

A select asserts only while the bus strobe is active and the cycle type is a memory cycle or an I/O cycle. Idle cycles and interrupt-acknowledge cycles never assert a select. The selects are combinational from the bus inputs, so they follow the address in the same cycle. The configuration registers use synchronous reset. After reset every select is disabled, and a new configuration applies from the clock edge that captures the write.

Top module: `iocs_decoder`

## Requirements
- R1: There are `NUM_CS` (default 2) select outputs `cs_n`, all active low. Each has its own base, size and enable. A configuration write to one select leaves the others unchanged.
- R2: While `rst_n` is low at a clock edge, all configurations are cleared and disabled. From the next cycle every `cs_n` bit is 1 until the select is enabled again.
- R3: Size code k (0 to 6) gives a window of 8·2^k bytes. Address bits 15 down to 3+k are compared with the same bits of the base, and lower bits of both are ignored.
- R4: Size codes 7 and above act as code 6. The window is 512 bytes and only bits 15:9 are compared.
- R5: With `bus_cycle` = 2'b01 (memory), strobe high, the select enabled and the address matching, the select is low.
- R6: With `bus_cycle` = 2'b10 (I/O), under the same conditions, the select is low.
- R7: With `bus_cycle` = 2'b11 (interrupt acknowledge), every `cs_n` bit is 1 for any address.
- R8: While `bus_strobe` is low, every `cs_n` bit is 1.
- R9: A select whose enable bit is 0 stays at 1 for any bus activity.
- R10: A write with `cfg_wr` = 1 loads `cfg_base`, `cfg_size` and `cfg_en` into the select chosen by `cfg_chan` at the clock edge. Outputs in the write cycle itself still reflect the old configuration.
- R11: With `bus_cycle` = 2'b00 (idle), every `cs_n` bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration registers |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_chan | input | CHAN_W (1) | Index of the select being written |
| cfg_base | input | 16 | Base address to load |
| cfg_size | input | 3 | Window size code to load |
| cfg_en | input | 1 | Enable bit to load |
| bus_addr | input | 16 | Low 16 bits of the processor address |
| bus_strobe | input | 1 | Bus cycle strobe, active high |
| bus_cycle | input | 2 | Cycle type: 00 idle, 01 memory, 10 I/O, 11 interrupt acknowledge |
| cs_n | output | NUM_CS (2) | Active-low chip selects |

## Verification
Bus-side results have zero latency. A change on `bus_addr`, `bus_strobe` or `bus_cycle` appears on `cs_n` in the same cycle. Configuration results have a latency of one edge. A write shows no effect while it is presented and takes effect after the edge that captures it. The bench drives inputs just after the rising edge and samples `cs_n` at the falling edge. Its behavioural model updates its stored configuration on the same rising edges, so every sample is compared against the configuration in force during that cycle. One directed check samples the write cycle itself to confirm that the old configuration still holds there.

// File: rtl/iocs_pkg.sv
// Package: shared constants and types for the I/O chip-select decoder.
// Assumes a 16-bit decoded address and a 3-bit window size code.
package iocs_pkg;
    localparam int ADDR_W = 16;
    localparam int SIZE_W = 3;

    typedef enum logic [1:0] {
        CYC_IDLE = 2'b00,
        CYC_MEM  = 2'b01,
        CYC_IO   = 2'b10,
        CYC_INTA = 2'b11
    } bus_cycle_e;

    typedef struct packed {
        logic              en;
        logic [SIZE_W-1:0] size;
        logic [ADDR_W-1:0] base;
    } cs_cfg_t;
endpackage

// File: rtl/iocs_cfg_regs.sv
// Module: configuration register bank, one entry per chip select.
// Assumes a single write port. Only the addressed entry changes on a write.
// Synchronous active-low reset clears and disables every entry.
module iocs_cfg_regs
    import iocs_pkg::*;
#(
    parameter int NUM_CS = 2,
    parameter int CHAN_W = 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr,
    input  logic [CHAN_W-1:0]       wr_chan,
    input  cs_cfg_t                 wr_cfg,
    output cs_cfg_t [NUM_CS-1:0]    cfg_q
);
    genvar g;
    generate
        for (g = 0; g < NUM_CS; g++) begin : g_entry
            // Hold or load the configuration of select g.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    cfg_q[g] <= '0;
                end else if (wr && (wr_chan == CHAN_W'(g))) begin
                    cfg_q[g] <= wr_cfg;
                end
            end
        end
    endgenerate
endmodule

// File: rtl/iocs_window_mask.sv
// Module: turns a size code into a mask of the compared address bits.
// Assumes code k means a window of 2^(MIN_LOG2+k) bytes and clamps k at MAX_CODE.
module iocs_window_mask
    import iocs_pkg::*;
#(
    parameter int MIN_LOG2 = 3,
    parameter int MAX_CODE = 6
) (
    input  logic [SIZE_W-1:0] size_code,
    output logic [ADDR_W-1:0] cmp_mask
);
    logic [SIZE_W-1:0] code_eff;

    // Clamp the size code to the largest legal window.
    always_comb begin
        if (int'(size_code) > MAX_CODE) code_eff = SIZE_W'(MAX_CODE);
        else                            code_eff = size_code;
    end

    // Set the mask bits at and above the window boundary.
    always_comb begin
        for (int i = 0; i < ADDR_W; i++) begin
            cmp_mask[i] = (i >= MIN_LOG2 + int'(code_eff));
        end
    end
endmodule

// File: rtl/iocs_addr_match.sv
// Module: masked equality compare between a bus address and a base.
// Assumes the mask marks the bits that take part in the compare.
module iocs_addr_match
    import iocs_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W-1:0] base,
    input  logic [ADDR_W-1:0] mask,
    output logic              hit
);
    // Report a hit when no compared bit differs.
    always_comb begin
        hit = ~|((addr ^ base) & mask);
    end
endmodule

// File: rtl/iocs_cycle_qual.sv
// Module: decides whether the current bus cycle may drive a chip select.
// Assumes the strobe marks a valid cycle. Only memory and I/O cycles qualify.
module iocs_cycle_qual
    import iocs_pkg::*;
(
    input  logic       strobe,
    input  logic [1:0] cycle,
    output logic       qual
);
    // Allow decode only for strobed memory or I/O cycles.
    always_comb begin
        unique case (bus_cycle_e'(cycle))
            CYC_MEM, CYC_IO: qual = strobe;
            default:         qual = 1'b0;
        endcase
    end
endmodule

// File: rtl/iocs_decoder.sv
// Module: top of the programmable I/O chip-select decoder.
// Each select compares the upper address bits against its programmed base.
// The size code sets the width of the compare. Outputs are combinational,
// active low, and gated by the cycle qualifier and the select's enable bit.
module iocs_decoder
    import iocs_pkg::*;
#(
    parameter int NUM_CS   = 2,
    parameter int MIN_LOG2 = 3,
    parameter int MAX_CODE = 6,
    localparam int CHAN_W  = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_wr,
    input  logic [CHAN_W-1:0]   cfg_chan,
    input  logic [ADDR_W-1:0]   cfg_base,
    input  logic [SIZE_W-1:0]   cfg_size,
    input  logic                cfg_en,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_strobe,
    input  logic [1:0]          bus_cycle,
    output logic [NUM_CS-1:0]   cs_n
);
    cs_cfg_t              wr_cfg;
    cs_cfg_t [NUM_CS-1:0] cfg_q;
    logic                 cyc_ok;

    // Pack the write fields into one configuration word.
    always_comb begin
        wr_cfg.en   = cfg_en;
        wr_cfg.size = cfg_size;
        wr_cfg.base = cfg_base;
    end

    iocs_cfg_regs #(.NUM_CS(NUM_CS), .CHAN_W(CHAN_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (cfg_wr),
        .wr_chan (cfg_chan),
        .wr_cfg  (wr_cfg),
        .cfg_q   (cfg_q)
    );

    iocs_cycle_qual u_qual (
        .strobe (bus_strobe),
        .cycle  (bus_cycle),
        .qual   (cyc_ok)
    );

    genvar g;
    generate
        for (g = 0; g < NUM_CS; g++) begin : g_sel
            logic [ADDR_W-1:0] mask;
            logic              hit;

            iocs_window_mask #(.MIN_LOG2(MIN_LOG2), .MAX_CODE(MAX_CODE)) u_mask (
                .size_code (cfg_q[g].size),
                .cmp_mask  (mask)
            );

            iocs_addr_match u_match (
                .addr (bus_addr),
                .base (cfg_q[g].base),
                .mask (mask),
                .hit  (hit)
            );

            // Drive select g low only for a qualified, enabled hit.
            always_comb begin
                cs_n[g] = ~(cyc_ok & cfg_q[g].en & hit);
            end
        end
    endgenerate
endmodule

// File: rtl/iocs_decoder_chk.sv
// Module: property checker for iocs_decoder, attached through bind.
// Assumes only the top-level ports are visible.
module iocs_decoder_chk #(
    parameter int NUM_CS = 2,
    parameter int CHAN_W = 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_wr,
    input logic [CHAN_W-1:0] cfg_chan,
    input logic              cfg_en,
    input logic              bus_strobe,
    input logic [1:0]        bus_cycle,
    input logic [NUM_CS-1:0] cs_n
);
    // R2
    reset_idle_chk: assert property (@(posedge clk) !rst_n |=> &cs_n);

    // R7
    inta_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cycle == 2'b11) |-> &cs_n);

    // R8
    strobe_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_strobe |-> &cs_n);

    // R11
    idle_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cycle == 2'b00) |-> &cs_n);

    genvar g;
    generate
        for (g = 0; g < NUM_CS; g++) begin : g_dis
            // R9
            disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (cfg_wr && cfg_chan == CHAN_W'(g) && !cfg_en) |=> cs_n[g]);
        end
    endgenerate
endmodule

bind iocs_decoder iocs_decoder_chk #(.NUM_CS(NUM_CS), .CHAN_W(CHAN_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_wr     (cfg_wr),
    .cfg_chan   (cfg_chan),
    .cfg_en     (cfg_en),
    .bus_strobe (bus_strobe),
    .bus_cycle  (bus_cycle),
    .cs_n       (cs_n)
);

// File: tb/iocs_decoder_bench.sv
module iocs_decoder_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [0:0]  cfg_chan = '0;
    logic [15:0] cfg_base = '0;
    logic [2:0]  cfg_size = '0;
    logic        cfg_en = 1'b0;
    logic [15:0] bus_addr = '0;
    logic        bus_strobe = 1'b0;
    logic [1:0]  bus_cycle = 2'b00;
    logic [1:0]  cs_n;

    int    n_tests = 0;
    int    n_fail  = 0;
    int    cycles  = 0;
    string cur_req = "R2";

    logic [15:0] m_base [2];
    int          m_size [2];
    bit          m_en   [2];

    iocs_decoder u_iocs_decoder (.*);

    always #2.5 clk = ~clk;

    // Reference model: stored configuration, updated on rising edges.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 2; i++) begin
                m_base[i] = '0; m_size[i] = 0; m_en[i] = 0;
            end
        end else if (cfg_wr) begin
            m_base[cfg_chan] = cfg_base;
            m_size[cfg_chan] = int'(cfg_size);
            m_en[cfg_chan]   = cfg_en;
        end
    end

    function automatic logic [1:0] model_cs();
        logic [1:0] r = 2'b11;
        for (int i = 0; i < 2; i++) begin
            int sh = 3 + ((m_size[i] > 6) ? 6 : m_size[i]);
            bit ok = bus_strobe && (bus_cycle == 2'b01 || bus_cycle == 2'b10);
            if (ok && m_en[i] && ((bus_addr >> sh) == (m_base[i] >> sh))) r[i] = 1'b0;
        end
        return r;
    endfunction

    task automatic check(input string req, input logic [1:0] act, input logic [1:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: cs_n actual=%b expected=%b (t=%0t)", req, act, exp, $time);
        end
    endtask

    // Compare the design against the model on every cycle after reset.
    always @(negedge clk) begin
        cycles++;
        if (rst_n) check({cur_req, " model"}, cs_n, model_cs());
        if (cycles > 100000) begin
            n_fail++;
            $display("FAIL watchdog: all requirements, actual=timeout expected=finish");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    task automatic write_cfg(input int ch, input logic [15:0] b, input int sz, input bit en);
        @(posedge clk); #1;
        cfg_wr = 1'b1; cfg_chan = 1'(ch); cfg_base = b; cfg_size = 3'(sz); cfg_en = en;
        @(posedge clk); #1;
        cfg_wr = 1'b0;
    endtask

    task automatic bus(input logic [1:0] cyc, input logic [15:0] a, input logic stb);
        @(posedge clk); #1;
        bus_cycle = cyc; bus_addr = a; bus_strobe = stb;
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R2: after reset both selects are idle, even for a base-0 address
        bus(2'b01, 16'h0000, 1'b1); check("R2", cs_n, 2'b11);

        cur_req = "R3";
        write_cfg(0, 16'h1230, 0, 1);
        write_cfg(1, 16'h4000, 6, 1);
        bus(2'b01, 16'h1237, 1'b1); check("R3", cs_n, 2'b10);
        bus(2'b01, 16'h1238, 1'b1); check("R3", cs_n, 2'b11);
        bus(2'b01, 16'h122F, 1'b1); check("R3", cs_n, 2'b11);
        bus(2'b01, 16'h41FF, 1'b1); check("R3", cs_n, 2'b01);
        bus(2'b01, 16'h4200, 1'b1); check("R3", cs_n, 2'b11);
        write_cfg(0, 16'h8040, 3, 1);
        bus(2'b01, 16'h807F, 1'b1); check("R3", cs_n, 2'b10);
        bus(2'b01, 16'h8080, 1'b1); check("R3", cs_n, 2'b11);
        bus(2'b01, 16'h803F, 1'b1); check("R3", cs_n, 2'b11);

        cur_req = "R4";
        write_cfg(1, 16'h40AB, 7, 1);
        bus(2'b01, 16'h4000, 1'b1); check("R4", cs_n, 2'b01);
        bus(2'b01, 16'h41FF, 1'b1); check("R4", cs_n, 2'b01);
        bus(2'b01, 16'h4200, 1'b1); check("R4", cs_n, 2'b11);

        cur_req = "R5";
        bus(2'b01, 16'h8041, 1'b1); check("R5", cs_n, 2'b10);
        cur_req = "R6";
        bus(2'b10, 16'h8041, 1'b1); check("R6", cs_n, 2'b10);
        bus(2'b10, 16'h4100, 1'b1); check("R6", cs_n, 2'b01);
        cur_req = "R7";
        bus(2'b11, 16'h8041, 1'b1); check("R7", cs_n, 2'b11);
        bus(2'b11, 16'h4100, 1'b1); check("R7", cs_n, 2'b11);
        cur_req = "R11";
        bus(2'b00, 16'h8041, 1'b1); check("R11", cs_n, 2'b11);
        cur_req = "R8";
        bus(2'b01, 16'h8041, 1'b0); check("R8", cs_n, 2'b11);
        bus(2'b10, 16'h4100, 1'b0); check("R8", cs_n, 2'b11);

        // R9 and R1: disabling select 0 leaves select 1 working
        cur_req = "R9";
        write_cfg(0, 16'h8040, 3, 0);
        bus(2'b01, 16'h8041, 1'b1); check("R9", cs_n, 2'b11);
        bus(2'b01, 16'h4100, 1'b1); check("R1", cs_n, 2'b01);

        // R10: old configuration holds during the write cycle, new one after
        cur_req = "R10";
        bus(2'b01, 16'h2000, 1'b1); check("R10", cs_n, 2'b11);
        @(posedge clk); #1;
        cfg_wr = 1'b1; cfg_chan = 1'b0; cfg_base = 16'h2000; cfg_size = 3'd1; cfg_en = 1'b1;
        @(negedge clk); check("R10", cs_n, 2'b11);
        @(posedge clk); #1; cfg_wr = 1'b0;
        @(negedge clk); check("R10", cs_n, 2'b10);
        bus(2'b01, 16'h200F, 1'b1); check("R10", cs_n, 2'b10);
        bus(2'b01, 16'h41F0, 1'b1); check("R1", cs_n, 2'b01);

        // Randomised traffic against the model (R1, R3, R4, R10)
        cur_req = "R1";
        for (int n = 0; n < 600; n++) begin
            @(posedge clk); #1;
            cfg_wr = (($urandom % 8) == 0);
            cfg_chan = 1'($urandom);
            cfg_base = 16'($urandom);
            cfg_size = 3'($urandom);
            cfg_en = (($urandom % 4) != 0);
            bus_cycle = 2'($urandom);
            bus_strobe = (($urandom % 5) != 0);
            bus_addr = m_base[$urandom % 2] ^ 16'($urandom % 1024);
        end
        @(posedge clk); #1; cfg_wr = 1'b0;

        // R2: reset again returns every select to idle
        cur_req = "R2";
        rst_n = 1'b0;
        @(posedge clk); #1; rst_n = 1'b1;
        bus_cycle = 2'b01; bus_strobe = 1'b1; bus_addr = 16'h0000;
        @(negedge clk); check("R2", cs_n, 2'b11);

        @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule